// File: doc/BRIEF.md
# Paged Address Translator with Access Protection

The block turns a 16-bit virtual address into a 15-bit physical address, using a 16-entry page table that it holds itself. Software loads an entry through a write port (an index plus an 8-bit entry word). Every request names an access kind (read, write or execute) and a privilege level. The upper four address bits select a page entry. The entry's 3-bit frame number replaces those bits, and the 12-bit offset passes through unchanged.

Before the block produces an address, it checks the entry. A page that is not present raises a not-present fault. An access that the entry's rights forbid raises a permission fault. In both cases no address is produced. Results are registered: they appear one clock cycle after the request and last for one cycle.

Entry word layout: bit 7 present, bit 6 user-allowed, bit 5 read, bit 4 write, bit 3 execute, bits 2:0 frame number. Access code: 0 read, 1 write, 2 execute, 3 reserved. Fault type code: 0 none, 1 not present, 2 permission.

Top module: `pg_xlate`

## Requirements
- R1: After reset, all 16 entries are not present, and valid_o, fault_o, fault_type_o and paddr_o are 0.
- R2: For a request that passes its checks, valid_o is 1 in the cycle after the request. In that cycle paddr_o = frame*4096 + (vaddr_i mod 4096); for example, page 5 mapped to frame 3 turns 20500 into 12308.
- R3: A request to an entry whose present bit (bit 7) is 0 gives fault_o=1, fault_type_o=1, valid_o=0 and paddr_o=0 in the next cycle.
- R4: A user-mode request (priv_i=0) to a present entry whose user-allowed bit (bit 6) is 0 gives fault_o=1, fault_type_o=2, valid_o=0 and paddr_o=0.
- R5: A privileged request (priv_i=1) ignores the user-allowed bit.
- R6: A read (code 0) needs bit 5, a write (code 1) needs bit 4 and an execute (code 2) needs bit 3, in both modes. Code 3 always gives a permission fault (type 2).
- R7: When an entry is not present, the fault type is 1 whatever its permission bits hold.
- R8: A table write takes effect for requests from the next cycle on. A request in the same cycle as the write uses the old entry.
- R9: In the cycle after a cycle with req_i=0, valid_o, fault_o and fault_type_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write one page entry |
| wr_idx_i | input | 4 | Page index to write |
| wr_entry_i | input | 8 | Entry word to store |
| req_i | input | 1 | Translation request |
| vaddr_i | input | 16 | Virtual address |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| priv_i | input | 1 | 1 = privileged, 0 = user |
| valid_o | output | 1 | Translation produced |
| paddr_o | output | 15 | Physical address, 0 unless valid_o |
| fault_o | output | 1 | Request refused |
| fault_type_o | output | 2 | 0 none, 1 not present, 2 permission |

## Verification
The assertions expect req_i to be 0 or 1, never unknown, from reset on. They also expect each registered result to stem from the request of the cycle before, so a valid result is checked against the sampled offset. The bench drives every input at the falling edge, holds it steady through the rising edge, and keeps req_i low when idle. Random table writes and requests cover all access codes and both modes. Directed cases add a write and a request to the same page in one cycle, pages that are not present with all permission bits set, and a reserved access code.

// File: rtl/pg_xlate_pkg.sv
package pg_xlate_pkg;
  parameter int VA_W   = 16;
  parameter int OFF_W  = 12;
  parameter int FRM_W  = 3;
  localparam int IDX_W = VA_W - OFF_W;
  localparam int NPAGE = 1 << IDX_W;
  localparam int PA_W  = FRM_W + OFF_W;
  localparam int ENT_W = 5 + FRM_W;

  typedef struct packed {
    logic             present;
    logic             user_ok;
    logic             rd_ok;
    logic             wr_ok;
    logic             ex_ok;
    logic [FRM_W-1:0] frame;
  } pte_t;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_NP   = 2'd1,
    FLT_PERM = 2'd2
  } flt_e;
endpackage

// File: rtl/pg_table.sv
module pg_table
  import pg_xlate_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  pte_t             wr_pte_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output pte_t             rd_pte_o
);
  pte_t tbl [NPAGE];

  for (genvar g = 0; g < NPAGE; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 tbl[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))   tbl[g] <= wr_pte_i;
    end
  end

  assign rd_pte_o = tbl[rd_idx_i];
endmodule

// File: rtl/pg_perm_chk.sv
module pg_perm_chk
  import pg_xlate_pkg::*;
(
  input  pte_t       pte_i,
  input  logic [1:0] acc_i,
  input  logic       priv_i,
  output flt_e       flt_o
);
  logic right_ok;

  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_RD:  right_ok = pte_i.rd_ok;
      ACC_WR:  right_ok = pte_i.wr_ok;
      ACC_EX:  right_ok = pte_i.ex_ok;
      default: right_ok = 1'b0;
    endcase
  end

  // not-present wins over any permission result
  always_comb begin
    if (!pte_i.present)                    flt_o = FLT_NP;
    else if (!priv_i && !pte_i.user_ok)    flt_o = FLT_PERM;
    else if (!right_ok)                    flt_o = FLT_PERM;
    else                                   flt_o = FLT_NONE;
  end
endmodule

// File: rtl/pg_xlate.sv
module pg_xlate
  import pg_xlate_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [ENT_W-1:0]      wr_entry_i,
  input  logic                  req_i,
  input  logic [VA_W-1:0]       vaddr_i,
  input  logic [1:0]            acc_i,
  input  logic                  priv_i,
  output logic                  valid_o,
  output logic [PA_W-1:0]       paddr_o,
  output logic                  fault_o,
  output logic [1:0]            fault_type_o
);
  pte_t cur_pte;
  flt_e cur_flt;

  pg_table i_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_pte_i (pte_t'(wr_entry_i)),
    .rd_idx_i (vaddr_i[VA_W-1:OFF_W]),
    .rd_pte_o (cur_pte)
  );

  pg_perm_chk i_chk (
    .pte_i  (cur_pte),
    .acc_i  (acc_i),
    .priv_i (priv_i),
    .flt_o  (cur_flt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      fault_o      <= 1'b0;
      fault_type_o <= FLT_NONE;
      paddr_o      <= '0;
    end else begin
      valid_o      <= req_i && (cur_flt == FLT_NONE);
      fault_o      <= req_i && (cur_flt != FLT_NONE);
      fault_type_o <= req_i ? cur_flt : FLT_NONE;
      paddr_o      <= (req_i && cur_flt == FLT_NONE) ?
                      {cur_pte.frame, vaddr_i[OFF_W-1:0]} : '0;
    end
  end
endmodule

// File: rtl/pg_xlate_chk.sv
module pg_xlate_chk
  import pg_xlate_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic [VA_W-1:0] vaddr_i,
  input logic            valid_o,
  input logic [PA_W-1:0] paddr_o,
  input logic            fault_o,
  input logic [1:0]      fault_type_o
);
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!valid_o && !fault_o && fault_type_o == 2'd0));

  assert_offset_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (!valid_o || paddr_o[OFF_W-1:0] == $past(vaddr_i[OFF_W-1:0])));

  assert_fault_no_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!valid_o && paddr_o == '0));

  assert_type_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (fault_type_o == 2'd1 || fault_type_o == 2'd2));

  assert_type_only_on_fault_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> fault_type_o == 2'd0);
endmodule

bind pg_xlate pg_xlate_chk i_pg_xlate_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .vaddr_i      (vaddr_i),
  .valid_o      (valid_o),
  .paddr_o      (paddr_o),
  .fault_o      (fault_o),
  .fault_type_o (fault_type_o)
);

// File: tb/test_pg_xlate.sv
module test_pg_xlate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_idx_i = '0;
  logic [7:0]  wr_entry_i = '0;
  logic        req_i = 1'b0;
  logic [15:0] vaddr_i = '0;
  logic [1:0]  acc_i = '0;
  logic        priv_i = 1'b0;
  logic        valid_o;
  logic [14:0] paddr_o;
  logic        fault_o;
  logic [1:0]  fault_type_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] model [16];

  always #5 clk_i = ~clk_i;

  pg_xlate i_pg_xlate (.*);

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // expected {valid, fault, type, paddr}
  function automatic logic [18:0] expect_f(logic [7:0] e, logic [15:0] va,
                                          logic [1:0] acc, logic pv);
    logic ok;
    case (acc)
      2'd0: ok = e[5];
      2'd1: ok = e[4];
      2'd2: ok = e[3];
      default: ok = 1'b0;
    endcase
    if (!e[7])             return {1'b0, 1'b1, 2'd1, 15'd0};
    if (!pv && !e[6])      return {1'b0, 1'b1, 2'd2, 15'd0};
    if (!ok)               return {1'b0, 1'b1, 2'd2, 15'd0};
    return {1'b1, 1'b0, 2'd0, e[2:0], va[11:0]};
  endfunction

  task automatic check(string tag, logic [18:0] exp);
    logic [18:0] act;
    act = {valid_o, fault_o, fault_type_o, paddr_o};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic write_pte(logic [3:0] idx, logic [7:0] e);
    wr_en_i = 1'b1; wr_idx_i = idx; wr_entry_i = e;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    model[idx] = e;
  endtask

  task automatic access(string tag, logic [15:0] va, logic [1:0] acc, logic pv);
    logic [18:0] exp;
    exp = expect_f(model[va[15:12]], va, acc, pv);
    req_i = 1'b1; vaddr_i = va; acc_i = acc; priv_i = pv;
    @(negedge clk_i);
    req_i = 1'b0;
    check(tag, exp);
  endtask

  initial begin
    logic [18:0] e_old;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    #1;
    n_tests++;
    if ({valid_o, fault_o, fault_type_o, paddr_o} !== 19'd0) begin
      n_fail++; $display("FAIL R1 reset outputs act=%h exp=0",
                         {valid_o, fault_o, fault_type_o, paddr_o});
    end
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    access("R1 empty table", 16'h7123, 2'd0, 1'b1);

    write_pte(4'd5, 8'hF8 | 8'd3);            // all rights, frame 3
    write_pte(4'd0, 8'hF8 | 8'd2);
    access("R2 20500->12308", 16'd20500, 2'd0, 1'b0);
    check("R2 value", {1'b1, 1'b0, 2'd0, 15'd12308});
    access("R2 1026->9218", 16'd1026, 2'd0, 1'b0);
    check("R2 value", {1'b1, 1'b0, 2'd0, 15'd9218});

    write_pte(4'd8, 8'h78 | 8'd1);            // not present, all rights
    access("R3 page 8 not present", 16'd32780, 2'd0, 1'b1);
    access("R7 np beats rights", 16'd32780, 2'd3, 1'b0);
    write_pte(4'd8, 8'hF8 | 8'd1);
    access("R2 32780->4108", 16'd32780, 2'd0, 1'b0);
    check("R2 value", {1'b1, 1'b0, 2'd0, 15'd4108});

    write_pte(4'd3, 8'hB8 | 8'd6);            // kernel only
    access("R4 user denied", 16'h3004, 2'd0, 1'b0);
    access("R5 priv bypass", 16'h3004, 2'd2, 1'b1);

    write_pte(4'd4, 8'hE0 | 8'd4);            // read only
    access("R6 read ok", 16'h4010, 2'd0, 1'b0);
    access("R6 write denied", 16'h4010, 2'd1, 1'b1);
    access("R6 exec denied", 16'h4010, 2'd2, 1'b1);
    access("R6 reserved code", 16'd20500, 2'd3, 1'b1);

    // R8: write and request in the same cycle
    e_old = expect_f(model[5], 16'h5ABC, 2'd1, 1'b0);
    wr_en_i = 1'b1; wr_idx_i = 4'd5; wr_entry_i = 8'hD0 | 8'd7;
    req_i = 1'b1; vaddr_i = 16'h5ABC; acc_i = 2'd1; priv_i = 1'b0;
    @(negedge clk_i);
    wr_en_i = 1'b0; req_i = 1'b0; model[5] = 8'hD0 | 8'd7;
    check("R8 same cycle old entry", e_old);
    access("R8 new entry next cycle", 16'h5ABC, 2'd1, 1'b0);

    @(negedge clk_i);
    check("R9 idle", 19'd0);

    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 3) == 0)
        write_pte(4'($urandom_range(0, 15)), 8'($urandom));
      access("R6 random", 16'($urandom), 2'($urandom_range(0, 3)),
             1'($urandom_range(0, 1)));
      if ($urandom_range(0, 4) == 0) begin
        @(negedge clk_i);
        check("R9 random idle", 19'd0);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule